// File: doc/BRIEF.md
# Data Access Translation Fault Checker

This block screens every data memory access against the rules of the address translation scheme. It takes a virtual address with its size and access type, the current privilege mode, and the result of a lookup that an external translation array has already performed. It then decides, in one cycle, whether the access translates cleanly or raises a fault. On a clean translation it returns the physical address. On a fault it reports a fault class and a trap vector. It also captures three fault-status registers that the trap handler reads: the faulting address, a status word, and a formatted address that points at the page-table entry for the faulting page.

The checks form a fixed ladder, and the first check that trips decides the outcome: alignment, then virtual-address range, then the direct-mapped superpage window, then the lookup hit, then the per-mode permission and fault-on bits. Each rung sets its own combination of status flags. Capture of the status registers is withheld for speculative accesses, for page-table-entry loads and for accesses marked no-fault. The fault itself is still signalled, so a nested miss taken while the handler is fetching an entry does not overwrite the state of the original fault.

Top module: `dacc_fault_chk`

## Requirements
- R1: A request whose address ANDed with (2^req_size_lg − 1) is nonzero raises class ALIGN (code 1) with vector 0x0301. Its flags are WR (bit 0) for a write and zero for a read.
- R2: An address whose bits 63:42 are neither all ones nor all zeros raises class PAGE (code 2) with vector 0x0381. Its flags are BAD_VA (bit 5) and ACV (bit 1), plus WR for a write.
- R3: A valid address with bit 42 = 1 and bit 41 = 0 is a superpage access. Outside kernel mode (cur_mode 0) it raises class ACV (code 3), vector 0x0381, with flags ACV plus WR for a write. In kernel mode it succeeds with pa_out = req_va[39:0], whatever the lookup reports.
- R4: Otherwise a lookup miss sets flags DTB_MISS (bit 4) plus WR for a write. The class is DMISS (code 5, vector 0x0281) when req_pte is set and MISS (code 4, vector 0x0201) when it is not.
- R5: On a hit for a write, a clear tlb_wr_en[cur_mode] raises PAGE with flags WR, ACV, and FONW (bit 3) if tlb_fonw is set. Otherwise a set tlb_fonw raises PAGE with flags WR and FONW.
- R6: On a hit for a read, a clear tlb_rd_en[cur_mode] raises ACV with flags ACV, and FONR (bit 2) if tlb_fonr is set. Otherwise a set tlb_fonr raises PAGE with flags FONR.
- R7: The checks are prioritised in the order R1, R2, R3, R4, then R5/R6. Only the first failing check decides the class and flags.
- R8: On a captured fault, stat_reg is loaded with inst_opcode in bits 16:11, inst_ra in bits 10:6 and the fault flags in bits 5:0.
- R9: On a captured fault, va_reg is loaded with req_va, and vaform_reg with ptbr OR (req_va[42:13] shifted left by 3).
- R10: When req_spec, req_pte or req_nofault is set, va_reg, stat_reg and vaform_reg keep their values, while fault_vld, fault_cls and fault_vec still report the fault.
- R11: A successful non-superpage translation gives pa_out = {tlb_ppn, req_va[12:0]}. pa_out is zero after any fault or idle cycle.
- R12: All outputs are registered: a request presented before a rising edge is reported after that edge. Without req_vld, fault_vld is 0, fault_cls is 0 and fault_vec is 0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | An access is presented this cycle |
| req_va | input | 64 | Virtual address |
| req_size_lg | input | 2 | log2 of access size in bytes |
| req_wr | input | 1 | Access is a write |
| req_pte | input | 1 | Access is a page-table-entry load |
| req_nofault | input | 1 | Access carries the no-fault marker |
| req_spec | input | 1 | Access is on a speculative path |
| cur_mode | input | 2 | Privilege mode, 0 = kernel |
| inst_opcode | input | 6 | Opcode of the accessing instruction |
| inst_ra | input | 5 | Register field of the accessing instruction |
| ptbr | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | External lookup found an entry |
| tlb_ppn | input | 27 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| pa_out | output | 40 | Physical address of a clean translation |
| fault_vld | output | 1 | A fault was raised |
| fault_cls | output | 3 | Fault class code |
| fault_vec | output | 16 | Trap vector |
| va_reg | output | 64 | Captured faulting address |
| stat_reg | output | 17 | Captured status word |
| vaform_reg | output | 64 | Captured formatted address |

## Verification
Two functions can act in the same cycle. The first is several fault checks tripping at once, for example a misaligned access to an invalid address, or a superpage access that also shows a lookup miss; the priority ladder must pick exactly one outcome. The second is a fault raised during a suppressed access, where the fault must be reported while the status registers hold. Random requests are biased toward misaligned, out-of-range and superpage addresses, with the enable and fault-on bits and the suppression flags drawn freely, so these overlaps arise often. Directed cases add the exact pairings. Each cycle's class, vector, flags and captured registers are compared with a bench model that walks the ladder in order and tracks which capture it expects to have been withheld.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned VA_W     = 43;
    localparam int unsigned PA_W     = 40;
    localparam int unsigned PG_SHIFT = 13;
    localparam int unsigned MODE_W   = 2;
    localparam int unsigned OPC_W    = 6;
    localparam int unsigned RA_W     = 5;
    localparam int unsigned FLG_W    = 6;
    localparam int unsigned VEC_W    = 16;

    localparam logic [FLG_W-1:0] F_WR    = 6'h01;
    localparam logic [FLG_W-1:0] F_ACV   = 6'h02;
    localparam logic [FLG_W-1:0] F_FONR  = 6'h04;
    localparam logic [FLG_W-1:0] F_FONW  = 6'h08;
    localparam logic [FLG_W-1:0] F_MISS  = 6'h10;
    localparam logic [FLG_W-1:0] F_BADVA = 6'h20;

    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_ALIGN = 3'd1,
        CLS_PAGE  = 3'd2,
        CLS_ACV   = 3'd3,
        CLS_MISS  = 3'd4,
        CLS_DMISS = 3'd5
    } fault_cls_e;

    typedef struct packed {
        fault_cls_e       cls;
        logic [FLG_W-1:0] flags;
    } chk_res_t;

    function automatic logic [VEC_W-1:0] cls_vector(fault_cls_e c);
        case (c)
            CLS_ALIGN: return 16'h0301;
            CLS_PAGE:  return 16'h0381;
            CLS_ACV:   return 16'h0381;
            CLS_MISS:  return 16'h0201;
            CLS_DMISS: return 16'h0281;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/dacc_addr_screen.sv
module dacc_addr_screen
    import dacc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned VW = VA_W
) (
    input  logic [AW-1:0] va,
    input  logic [1:0]    size_lg,
    output logic          misalign,
    output logic          va_ok,
    output logic          superpg
);
    localparam int unsigned UP_W = AW - VW + 1;

    logic [AW-1:0]   amask;
    logic [UP_W-1:0] upper;

    always_comb begin
        amask    = (AW'(1) << size_lg) - AW'(1);
        misalign = |(va & amask);
        upper    = va[AW-1:VW-1];
        va_ok    = (&upper) | ~(|upper);
        superpg  = va_ok & va[VW-1] & ~va[VW-2];
    end
endmodule

// File: rtl/dacc_rule_ladder.sv
module dacc_rule_ladder
    import dacc_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned PW  = PA_W,
    parameter int unsigned PGS = PG_SHIFT,
    parameter int unsigned MW  = MODE_W,
    localparam int unsigned NMODE = 1 << MW,
    localparam int unsigned PPN_W = PW - PGS
) (
    input  logic [AW-1:0]    va,
    input  logic             misalign,
    input  logic             va_ok,
    input  logic             superpg,
    input  logic             is_wr,
    input  logic             is_pte,
    input  logic [MW-1:0]    mode,
    input  logic             hit,
    input  logic [PPN_W-1:0] ppn,
    input  logic [NMODE-1:0] rd_en,
    input  logic [NMODE-1:0] wr_en,
    input  logic             fonr,
    input  logic             fonw,
    output chk_res_t         res,
    output logic [PW-1:0]    pa
);
    logic [FLG_W-1:0] wrf;

    always_comb begin
        wrf       = is_wr ? F_WR : '0;
        res.cls   = CLS_NONE;
        res.flags = '0;
        pa        = '0;
        if (misalign) begin
            res.cls   = CLS_ALIGN;
            res.flags = wrf;
        end else if (!va_ok) begin
            res.cls   = CLS_PAGE;
            res.flags = wrf | F_BADVA | F_ACV;
        end else if (superpg) begin
            if (mode != MODE_KERNEL) begin
                res.cls   = CLS_ACV;
                res.flags = wrf | F_ACV;
            end else begin
                pa = va[PW-1:0];
            end
        end else if (!hit) begin
            res.cls   = is_pte ? CLS_DMISS : CLS_MISS;
            res.flags = wrf | F_MISS;
        end else if (is_wr) begin
            if (!wr_en[mode]) begin
                res.cls   = CLS_PAGE;
                res.flags = F_WR | F_ACV | (fonw ? F_FONW : '0);
            end else if (fonw) begin
                res.cls   = CLS_PAGE;
                res.flags = F_WR | F_FONW;
            end else begin
                pa = {ppn, va[PGS-1:0]};
            end
        end else begin
            if (!rd_en[mode]) begin
                res.cls   = CLS_ACV;
                res.flags = F_ACV | (fonr ? F_FONR : '0);
            end else if (fonr) begin
                res.cls   = CLS_PAGE;
                res.flags = F_FONR;
            end else begin
                pa = {ppn, va[PGS-1:0]};
            end
        end
    end
endmodule

// File: rtl/dacc_capture.sv
module dacc_capture
    import dacc_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned VW  = VA_W,
    parameter int unsigned PW  = PA_W,
    parameter int unsigned PGS = PG_SHIFT,
    localparam int unsigned STAT_W = OPC_W + RA_W + FLG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic              suppress,
    input  chk_res_t          res,
    input  logic [PW-1:0]     pa_in,
    input  logic [AW-1:0]     va,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [RA_W-1:0]   ra,
    input  logic [AW-1:0]     ptbr,
    output logic [PW-1:0]     pa_q,
    output logic              fault_q,
    output fault_cls_e        cls_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [AW-1:0]     va_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [AW-1:0]     form_q
);
    logic is_fault;
    logic [AW-1:0] form_next;

    always_comb begin
        is_fault  = req_vld && (res.cls != CLS_NONE);
        form_next = ptbr | (AW'(va[VW-1:PGS]) << 3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q    <= '0;
            fault_q <= 1'b0;
            cls_q   <= CLS_NONE;
            vec_q   <= '0;
            va_q    <= '0;
            stat_q  <= '0;
            form_q  <= '0;
        end else begin
            pa_q    <= (req_vld && !is_fault) ? pa_in : '0;
            fault_q <= is_fault;
            cls_q   <= is_fault ? res.cls : CLS_NONE;
            vec_q   <= is_fault ? cls_vector(res.cls) : '0;
            if (is_fault && !suppress) begin
                va_q   <= va;
                stat_q <= {opcode, ra, res.flags};
                form_q <= form_next;
            end
        end
    end
endmodule

// File: rtl/dacc_fault_chk.sv
module dacc_fault_chk
    import dacc_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned VW  = VA_W,
    parameter int unsigned PW  = PA_W,
    parameter int unsigned PGS = PG_SHIFT,
    parameter int unsigned MW  = MODE_W,
    localparam int unsigned NMODE  = 1 << MW,
    localparam int unsigned PPN_W  = PW - PGS,
    localparam int unsigned STAT_W = OPC_W + RA_W + FLG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [AW-1:0]     req_va,
    input  logic [1:0]        req_size_lg,
    input  logic              req_wr,
    input  logic              req_pte,
    input  logic              req_nofault,
    input  logic              req_spec,
    input  logic [MW-1:0]     cur_mode,
    input  logic [OPC_W-1:0]  inst_opcode,
    input  logic [RA_W-1:0]   inst_ra,
    input  logic [AW-1:0]     ptbr,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [NMODE-1:0]  tlb_rd_en,
    input  logic [NMODE-1:0]  tlb_wr_en,
    input  logic              tlb_fonr,
    input  logic              tlb_fonw,
    output logic [PW-1:0]     pa_out,
    output logic              fault_vld,
    output logic [2:0]        fault_cls,
    output logic [VEC_W-1:0]  fault_vec,
    output logic [AW-1:0]     va_reg,
    output logic [STAT_W-1:0] stat_reg,
    output logic [AW-1:0]     vaform_reg
);
    logic       misalign, va_ok, superpg, suppress;
    chk_res_t   res;
    logic [PW-1:0] pa_c;
    fault_cls_e cls_q;

    assign suppress  = req_spec | req_pte | req_nofault;
    assign fault_cls = cls_q;

    dacc_addr_screen #(.AW(AW), .VW(VW)) u_screen (
        .va(req_va), .size_lg(req_size_lg),
        .misalign(misalign), .va_ok(va_ok), .superpg(superpg)
    );

    dacc_rule_ladder #(.AW(AW), .PW(PW), .PGS(PGS), .MW(MW)) u_ladder (
        .va(req_va), .misalign(misalign), .va_ok(va_ok), .superpg(superpg),
        .is_wr(req_wr), .is_pte(req_pte), .mode(cur_mode),
        .hit(tlb_hit), .ppn(tlb_ppn), .rd_en(tlb_rd_en), .wr_en(tlb_wr_en),
        .fonr(tlb_fonr), .fonw(tlb_fonw), .res(res), .pa(pa_c)
    );

    dacc_capture #(.AW(AW), .VW(VW), .PW(PW), .PGS(PGS)) u_capture (
        .clk(clk), .rst(rst), .req_vld(req_vld), .suppress(suppress),
        .res(res), .pa_in(pa_c), .va(req_va), .opcode(inst_opcode),
        .ra(inst_ra), .ptbr(ptbr), .pa_q(pa_out), .fault_q(fault_vld),
        .cls_q(cls_q), .vec_q(fault_vec), .va_q(va_reg),
        .stat_q(stat_reg), .form_q(vaform_reg)
    );
endmodule

// File: rtl/dacc_fault_sva.sv
module dacc_fault_sva
    import dacc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned VW = VA_W,
    localparam int unsigned STAT_W = OPC_W + RA_W + FLG_W,
    localparam int unsigned UP_W   = AW - VW + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [AW-1:0]     req_va,
    input logic [1:0]        req_size_lg,
    input logic              req_pte,
    input logic              req_nofault,
    input logic              req_spec,
    input logic              fault_vld,
    input logic [2:0]        fault_cls,
    input logic [VEC_W-1:0]  fault_vec,
    input logic [AW-1:0]     va_reg,
    input logic [STAT_W-1:0] stat_reg,
    input logic [AW-1:0]     vaform_reg
);
    logic            mis_a;
    logic            bad_a;
    logic [UP_W-1:0] up_a;

    always_comb begin
        mis_a = |(req_va & ((AW'(1) << req_size_lg) - AW'(1)));
        up_a  = req_va[AW-1:VW-1];
        bad_a = !((&up_a) || !(|up_a));
    end

    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mis_a) |=> (fault_vld && fault_cls == 3'd1)); // R1

    AST_ALIGN_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (fault_vld && fault_cls == 3'd1) |-> fault_vec == 16'h0301); // R1

    AST_BADVA_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !mis_a && bad_a && !req_spec && !req_pte && !req_nofault)
        |=> (stat_reg[5] && stat_reg[1] && fault_cls == 3'd2)); // R2

    AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_spec || req_pte || req_nofault || !req_vld)
        |=> ($stable(va_reg) && $stable(stat_reg) && $stable(vaform_reg))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!fault_vld && fault_cls == 3'd0 && fault_vec == 16'h0)); // R12
endmodule

bind dacc_fault_chk dacc_fault_sva #(.AW(AW), .VW(VW)) u_sva (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_va(req_va),
    .req_size_lg(req_size_lg), .req_pte(req_pte), .req_nofault(req_nofault),
    .req_spec(req_spec), .fault_vld(fault_vld), .fault_cls(fault_cls),
    .fault_vec(fault_vec), .va_reg(va_reg), .stat_reg(stat_reg),
    .vaform_reg(vaform_reg)
);

// File: tb/dacc_fault_chk_tb.sv
`timescale 1ns/1ps
module dacc_fault_chk_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size_lg = '0;
    logic        req_wr = 1'b0, req_pte = 1'b0, req_nofault = 1'b0, req_spec = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [5:0]  inst_opcode = '0;
    logic [4:0]  inst_ra = '0;
    logic [63:0] ptbr = '0;
    logic        tlb_hit = 1'b0;
    logic [26:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
    logic [39:0] pa_out;
    logic        fault_vld;
    logic [2:0]  fault_cls;
    logic [15:0] fault_vec;
    logic [63:0] va_reg, vaform_reg;
    logic [16:0] stat_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] e_va = '0, e_form = '0;
    logic [16:0] e_stat = '0;

    always #2.5 clk = ~clk;

    dacc_fault_chk u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_va(req_va),
        .req_size_lg(req_size_lg), .req_wr(req_wr), .req_pte(req_pte),
        .req_nofault(req_nofault), .req_spec(req_spec), .cur_mode(cur_mode),
        .inst_opcode(inst_opcode), .inst_ra(inst_ra), .ptbr(ptbr),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en),
        .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
        .pa_out(pa_out), .fault_vld(fault_vld), .fault_cls(fault_cls),
        .fault_vec(fault_vec), .va_reg(va_reg), .stat_reg(stat_reg),
        .vaform_reg(vaform_reg)
    );

    function automatic logic [15:0] vec_of(logic [2:0] c);
        case (c)
            3'd1: return 16'h0301;
            3'd2, 3'd3: return 16'h0381;
            3'd4: return 16'h0201;
            3'd5: return 16'h0281;
            default: return 16'h0;
        endcase
    endfunction

    function automatic void model(output logic [2:0] cls, output logic [5:0] flg,
                                  output logic [39:0] pa);
        logic [5:0] w;
        logic [21:0] up;
        w = req_wr ? 6'h01 : 6'h00;
        up = req_va[63:42];
        cls = 3'd0; flg = 6'h0; pa = '0;
        if ((req_va & ((64'd1 << req_size_lg) - 64'd1)) != 0) begin
            cls = 3'd1; flg = w;
        end else if (!(up == '1 || up == '0)) begin
            cls = 3'd2; flg = w | 6'h22;
        end else if (req_va[42] && !req_va[41]) begin
            if (cur_mode != 2'd0) begin cls = 3'd3; flg = w | 6'h02; end
            else pa = req_va[39:0];
        end else if (!tlb_hit) begin
            cls = req_pte ? 3'd5 : 3'd4; flg = w | 6'h10;
        end else if (req_wr) begin
            if (!tlb_wr_en[cur_mode]) begin
                cls = 3'd2; flg = 6'h03 | (tlb_fonw ? 6'h08 : 6'h0);
            end else if (tlb_fonw) begin
                cls = 3'd2; flg = 6'h09;
            end else pa = {tlb_ppn, req_va[12:0]};
        end else begin
            if (!tlb_rd_en[cur_mode]) begin
                cls = 3'd3; flg = 6'h02 | (tlb_fonr ? 6'h04 : 6'h0);
            end else if (tlb_fonr) begin
                cls = 3'd2; flg = 6'h04;
            end else pa = {tlb_ppn, req_va[12:0]};
        end
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one request, wait through the registering edge, compare all outputs.
    task automatic access(string tag);
        logic [2:0] c; logic [5:0] f; logic [39:0] p;
        @(negedge clk);
        req_vld = 1'b1;
        model(c, f, p);
        if (c != 0 && !(req_spec || req_pte || req_nofault)) begin
            e_va   = req_va;
            e_stat = {inst_opcode, inst_ra, f};
            e_form = ptbr | ({34'd0, req_va[42:13]} << 3);
        end
        @(posedge clk); #1;
        chk(tag, "fault_vld", {63'd0, fault_vld}, {63'd0, c != 0});
        chk(tag, "fault_cls", {61'd0, fault_cls}, {61'd0, c});
        chk(tag, "fault_vec", {48'd0, fault_vec}, {48'd0, vec_of(c)});
        chk(tag, "pa_out", {24'd0, pa_out}, {24'd0, p});
        chk(tag, "va_reg", va_reg, e_va);
        chk(tag, "stat_reg", {47'd0, stat_reg}, {47'd0, e_stat});
        chk(tag, "vaform_reg", vaform_reg, e_form);
    endtask

    task automatic set_req(logic [63:0] va, logic [1:0] sz, logic wr, logic [1:0] md,
                           logic hit, logic [3:0] re, logic [3:0] we, logic fr, logic fw);
        req_va = va; req_size_lg = sz; req_wr = wr; cur_mode = md; tlb_hit = hit;
        tlb_rd_en = re; tlb_wr_en = we; tlb_fonr = fr; tlb_fonw = fw;
        req_pte = 0; req_nofault = 0; req_spec = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0dacc5));
        inst_opcode = 6'h2C; inst_ra = 5'h1F; ptbr = 64'h0000_0200_0000_0000;
        tlb_ppn = 27'h5A5A5A5;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "reset fault_vld", {63'd0, fault_vld}, 64'd0);
        chk("R12", "reset stat_reg", {47'd0, stat_reg}, 64'd0);
        chk("R12", "reset va_reg", va_reg, 64'd0);
        @(negedge clk); rst = 1'b0;

        set_req(64'h0000_0000_0012_3404, 2'd3, 1, 0, 1, 4'hF, 4'hF, 0, 0); access("R1");
        set_req(64'h0000_0000_0012_3401, 2'd1, 0, 0, 1, 4'hF, 4'hF, 0, 0); access("R1");
        set_req(64'h8000_0000_0000_0003, 2'd2, 1, 0, 0, 4'h0, 4'h0, 0, 0); access("R7");
        set_req(64'h8000_0000_0000_0000, 2'd3, 0, 0, 1, 4'hF, 4'hF, 0, 0); access("R2");
        set_req(64'h0000_1000_0000_0000, 2'd3, 1, 0, 1, 4'hF, 4'hF, 0, 0); access("R2");
        set_req(64'hFFFF_FC00_0000_1238, 2'd3, 1, 3, 1, 4'hF, 4'hF, 0, 0); access("R3");
        set_req(64'hFFFF_FC12_3456_7890, 2'd3, 0, 0, 0, 4'h0, 4'h0, 1, 1); access("R3");
        set_req(64'h0000_0000_0040_2000, 2'd3, 1, 1, 0, 4'hF, 4'hF, 0, 0); access("R4");
        set_req(64'h0000_0000_0040_2008, 2'd3, 0, 1, 0, 4'hF, 4'hF, 0, 0);
        req_pte = 1; access("R4");
        set_req(64'h0000_0000_0050_0010, 2'd2, 1, 2, 1, 4'hF, 4'hB, 0, 1); access("R5");
        set_req(64'h0000_0000_0050_0014, 2'd2, 1, 2, 1, 4'hF, 4'hF, 0, 1); access("R5");
        set_req(64'h0000_0000_0060_0020, 2'd2, 0, 3, 1, 4'h7, 4'hF, 1, 0); access("R6");
        set_req(64'h0000_0000_0060_0024, 2'd2, 0, 3, 1, 4'hF, 4'hF, 1, 0); access("R6");
        inst_opcode = 6'h3F; inst_ra = 5'h0A;
        set_req(64'h0000_07FF_FFFF_E000, 2'd0, 1, 0, 0, 4'hF, 4'hF, 0, 0); access("R8");
        ptbr = 64'h0000_0300_0000_0007;
        set_req(64'h0000_0123_4567_8000, 2'd0, 0, 1, 0, 4'hF, 4'hF, 0, 0); access("R9");
        set_req(64'h8000_0000_1111_0000, 2'd0, 0, 1, 0, 4'hF, 4'hF, 0, 0);
        req_spec = 1; access("R10");
        set_req(64'h0000_0000_0012_3401, 2'd2, 1, 0, 1, 4'hF, 4'hF, 0, 0);
        req_nofault = 1; access("R10");
        set_req(64'h0000_0000_00AB_CDE8, 2'd3, 1, 1, 1, 4'hF, 4'hF, 0, 0); access("R11");
        set_req(64'h0000_0000_00AB_CDE6, 2'd1, 0, 1, 1, 4'hF, 4'hF, 0, 0); access("R11");

        @(negedge clk); req_vld = 1'b0; req_va = 64'h8000_0000_0000_0001;
        @(posedge clk); #1;
        chk("R12", "idle fault_vld", {63'd0, fault_vld}, 64'd0);
        chk("R12", "idle fault_vec", {48'd0, fault_vec}, 64'd0);
        chk("R12", "idle pa_out", {24'd0, pa_out}, 64'd0);
        chk("R12", "idle va_reg", va_reg, e_va);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] v;
            logic [1:0]  sz;
            int unsigned k;
            k  = $urandom % 4;
            sz = 2'($urandom);
            if (k == 0) v = {$urandom, $urandom};
            else if (k == 3) v = {21'h1FFFFF, 2'b10, 9'($urandom), $urandom};
            else begin
                v[42:0]  = {11'($urandom), $urandom};
                v[63:43] = {21{v[42]}};
            end
            if ($urandom % 4 != 0) v = v & ~((64'd1 << sz) - 64'd1);
            set_req(v, sz, 1'($urandom), 2'($urandom), ($urandom % 4) != 0,
                    4'($urandom), 4'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
            req_pte = ($urandom % 6) == 0;
            req_spec = ($urandom % 6) == 0;
            req_nofault = ($urandom % 8) == 0;
            inst_opcode = 6'($urandom); inst_ra = 5'($urandom);
            ptbr = {$urandom, $urandom};
            tlb_ppn = 27'($urandom);
            access("R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule